// File: doc/BRIEF.md
# Reference-Calibrated Sample-Enable Generator

This block produces a steady sample-enable pulse train at a target rate, typically 240 kHz, or four times a 60 kHz carrier. It runs from a fast on-chip oscillator whose frequency is poorly known and drifts. A slow, accurate 32.768 kHz watch reference is brought in on the fast clock through a two-stage synchroniser and a rising-edge detector. The block counts fast-clock cycles across a fixed number of reference periods. With the default window of 32768 reference edges, that count is the oscillator frequency in Hz.

Each finished count is the divisor of a sequential restoring division. The dividend is a constant derived from the parameters. The quotient becomes the tuning word, or increment, of a phase-accumulator oscillator clocked by the fast clock. Every carry out of the accumulator yields one sample-enable pulse. A new increment is held pending and takes effect only in the cycle in which the accumulator wraps, so the phase stays continuous. Measurement repeats window after window, so the output rate follows the oscillator as it drifts.

Until the first calibrated increment takes effect, a parameter default is used and the done flag stays low.

Top module: `clkcal_top`

## Requirements
- R1: While reset is high and in the first cycle after it, sample_en is 0, inc_out equals DEFAULT_INC and cal_done is 0.
- R2: ref_in is passed through two flip-flops on the fast clock before use, and only its rising edges (a 0 then a 1 at the synchroniser output) are counted.
- R3: The first rising reference edge after reset opens a measurement window. The window closes on the WIN_EDGES-th rising edge after it, and the result is the number of fast cycles between those two edges (WIN_EDGES × reference period). The closing edge opens the next window.
- R4: The calibrated increment is floor(NUMER / count), where NUMER = TARGET_HZ × WIN_EDGES × 2^ACC_W / REF_HZ (integer division).
- R5: The increment used is clamped to the range 1 to 2^ACC_W − 1. A quotient of 0 gives 1, and a quotient above the maximum gives 2^ACC_W − 1.
- R6: inc_out changes only in a cycle in which sample_en is 1, that is, at an accumulator wrap.
- R7: sample_en is 1 for one cycle per accumulator carry. Over any 2^ACC_W consecutive cycles with a constant increment, exactly inc_out pulses occur. With an increment that divides 2^ACC_W, the pulses are evenly spaced 2^ACC_W / inc_out cycles apart.
- R8: Without a completed calibration, inc_out stays at DEFAULT_INC and cal_done stays 0, no matter how long the reference is absent.
- R9: cal_done rises in the cycle in which the first calibrated increment takes effect, and it then stays 1 until reset.
- R10: Calibration repeats for every window. After the reference period changes, inc_out settles to the value that R4 and R5 give for the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast internal oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Accurate slow reference, asynchronous to clk_fast |
| sample_en | output | 1 | One-cycle pulse per accumulator carry |
| inc_out | output | ACC_W | Increment currently driving the accumulator |
| cal_done | output | 1 | High once a calibrated increment is in effect |

## Verification
On every cycle, the assertions check the following:
- the increment never changes except together with a sample pulse;
- the increment is never zero;
- the default holds for as long as the done flag is low;
- the done flag is sticky and rises only at a wrap.

The following can only be shown by the bench's scenarios, which run the reference at several periods:
- the measured window length and the division result;
- the clamp of a zero quotient to 1;
- the exact number and spacing of pulses for a given increment.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;

    typedef enum logic {
        MTR_WAIT,
        MTR_RUN
    } mtr_state_e;

    function automatic longint unsigned numer_calc(
        input longint unsigned tgt_hz,
        input longint unsigned win_edges,
        input int              acc_w,
        input longint unsigned ref_hz
    );
        return ((tgt_hz * win_edges) << acc_w) / ref_hz;
    endfunction

endpackage

// File: rtl/clkcal_ref_sync.sv
module clkcal_ref_sync (
    input  logic clk,
    input  logic rst,
    input  logic ref_async,
    output logic ref_rise
);
    logic [2:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg <= {stg[1:0], ref_async};
        end
    end

    assign ref_rise = stg[1] & ~stg[2];
endmodule

// File: rtl/clkcal_meter.sv
module clkcal_meter #(
    parameter int CNT_W     = 32,
    parameter int WIN_EDGES = 32768
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_rise,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_count
);
    import clkcal_pkg::*;

    localparam int EW = $clog2(WIN_EDGES + 1);

    mtr_state_e       st;
    logic [EW-1:0]    edge_cnt;
    logic [CNT_W-1:0] cyc;
    logic [CNT_W-1:0] cyc_inc;

    assign cyc_inc = (cyc == '1) ? cyc : cyc + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= MTR_WAIT;
            edge_cnt   <= '0;
            cyc        <= '0;
            meas_valid <= 1'b0;
            meas_count <= '0;
        end else begin
            meas_valid <= 1'b0;
            case (st)
                MTR_WAIT: begin
                    if (ref_rise) begin
                        st       <= MTR_RUN;
                        cyc      <= CNT_W'(1);
                        edge_cnt <= '0;
                    end
                end
                default: begin
                    if (ref_rise && edge_cnt == EW'(WIN_EDGES - 1)) begin
                        meas_valid <= 1'b1;
                        meas_count <= cyc;
                        edge_cnt   <= '0;
                        cyc        <= CNT_W'(1);
                    end else begin
                        if (ref_rise) begin
                            edge_cnt <= edge_cnt + 1'b1;
                        end
                        cyc <= cyc_inc;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/clkcal_divider.sv
module clkcal_divider #(
    parameter int                 CNT_W = 32,
    parameter int                 DIV_W = 48,
    parameter logic [DIV_W-1:0]   NUMER = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [DIV_W-1:0] quotient
);
    localparam int CW = $clog2(DIV_W + 1);

    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] dvs;
    logic [DIV_W-1:0] dvd;
    logic [CW-1:0]    steps;
    logic [CNT_W:0]   trial;
    logic             fits;

    assign trial = {rem, dvd[DIV_W-1]};
    assign fits  = trial >= {1'b0, dvs};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem      <= '0;
            dvs      <= '0;
            dvd      <= '0;
            steps    <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            quotient <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    rem      <= '0;
                    dvs      <= divisor;
                    dvd      <= NUMER;
                    steps    <= CW'(DIV_W);
                    quotient <= '0;
                    busy     <= 1'b1;
                end
            end else begin
                rem      <= fits ? CNT_W'(trial - {1'b0, dvs}) : CNT_W'(trial);
                quotient <= {quotient[DIV_W-2:0], fits};
                dvd      <= dvd << 1;
                steps    <= steps - 1'b1;
                if (steps == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/clkcal_dco.sv
module clkcal_dco #(
    parameter int ACC_W       = 24,
    parameter int DEFAULT_INC = 335544
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_valid,
    input  logic [ACC_W-1:0] load_inc,
    output logic             sample_en,
    output logic [ACC_W-1:0] inc_out,
    output logic             cal_done
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] pend;
    logic             pend_v;
    logic [ACC_W:0]   sum;
    logic             carry;

    assign sum   = {1'b0, acc} + {1'b0, inc_out};
    assign carry = sum[ACC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            inc_out   <= ACC_W'(DEFAULT_INC);
            pend      <= '0;
            pend_v    <= 1'b0;
            sample_en <= 1'b0;
            cal_done  <= 1'b0;
        end else begin
            acc       <= sum[ACC_W-1:0];
            sample_en <= carry;
            if (carry && pend_v) begin
                inc_out  <= pend;
                cal_done <= 1'b1;
                pend_v   <= 1'b0;
            end
            if (load_valid) begin
                pend   <= load_inc;
                pend_v <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkcal_top.sv
module clkcal_top #(
    parameter int ACC_W       = 24,
    parameter int CNT_W       = 32,
    parameter int DIV_W       = 48,
    parameter int WIN_EDGES   = 32768,
    parameter int TARGET_HZ   = 240000,
    parameter int REF_HZ      = 32768,
    parameter int DEFAULT_INC = 335544
) (
    input  logic             clk_fast,
    input  logic             rst,
    input  logic             ref_in,
    output logic             sample_en,
    output logic [ACC_W-1:0] inc_out,
    output logic             cal_done
);
    localparam logic [DIV_W-1:0] NUMER = DIV_W'(clkcal_pkg::numer_calc(
        longint'(TARGET_HZ), longint'(WIN_EDGES), ACC_W, longint'(REF_HZ)));
    localparam logic [DIV_W-1:0] INC_MAX = DIV_W'((64'd1 << ACC_W) - 64'd1);

    logic             ref_rise;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_count;
    logic             div_busy;
    logic             quo_valid;
    logic [DIV_W-1:0] quo;
    logic [ACC_W-1:0] inc_clamped;

    clkcal_ref_sync u_sync (
        .clk       (clk_fast),
        .rst       (rst),
        .ref_async (ref_in),
        .ref_rise  (ref_rise)
    );

    clkcal_meter #(
        .CNT_W     (CNT_W),
        .WIN_EDGES (WIN_EDGES)
    ) u_meter (
        .clk        (clk_fast),
        .rst        (rst),
        .ref_rise   (ref_rise),
        .meas_valid (meas_valid),
        .meas_count (meas_count)
    );

    clkcal_divider #(
        .CNT_W (CNT_W),
        .DIV_W (DIV_W),
        .NUMER (NUMER)
    ) u_div (
        .clk      (clk_fast),
        .rst      (rst),
        .start    (meas_valid),
        .divisor  (meas_count),
        .busy     (div_busy),
        .done     (quo_valid),
        .quotient (quo)
    );

    always_comb begin
        if (quo == '0) begin
            inc_clamped = ACC_W'(1);
        end else if (quo > INC_MAX) begin
            inc_clamped = '1;
        end else begin
            inc_clamped = quo[ACC_W-1:0];
        end
    end

    clkcal_dco #(
        .ACC_W       (ACC_W),
        .DEFAULT_INC (DEFAULT_INC)
    ) u_dco (
        .clk        (clk_fast),
        .rst        (rst),
        .load_valid (quo_valid),
        .load_inc   (inc_clamped),
        .sample_en  (sample_en),
        .inc_out    (inc_out),
        .cal_done   (cal_done)
    );
endmodule

// File: rtl/clkcal_checker.sv
module clkcal_checker #(
    parameter int ACC_W       = 24,
    parameter int DEFAULT_INC = 335544
) (
    input logic             clk_fast,
    input logic             rst,
    input logic             sample_en,
    input logic [ACC_W-1:0] inc_out,
    input logic             cal_done,
    input logic             quo_valid
);
    p_inc_at_wrap_r6: assert property (@(posedge clk_fast) disable iff (rst)
        !$stable(inc_out) |-> sample_en);

    p_inc_nonzero_r5: assert property (@(posedge clk_fast) disable iff (rst)
        inc_out != '0);

    p_default_until_done_r8: assert property (@(posedge clk_fast) disable iff (rst)
        !cal_done |-> inc_out == ACC_W'(DEFAULT_INC));

    p_done_sticky_r9: assert property (@(posedge clk_fast) disable iff (rst)
        cal_done |=> cal_done);

    p_done_at_wrap_r9: assert property (@(posedge clk_fast) disable iff (rst)
        $rose(cal_done) |-> sample_en);

    p_result_single_r4: assert property (@(posedge clk_fast) disable iff (rst)
        quo_valid |=> !quo_valid);
endmodule

bind clkcal_top clkcal_checker #(
    .ACC_W       (ACC_W),
    .DEFAULT_INC (DEFAULT_INC)
) u_chk (
    .clk_fast  (clk_fast),
    .rst       (rst),
    .sample_en (sample_en),
    .inc_out   (inc_out),
    .cal_done  (cal_done),
    .quo_valid (quo_valid)
);

// File: tb/clkcal_top_bench.sv
module clkcal_top_bench;
    localparam int ACC_W  = 12;
    localparam int WIN    = 4;
    localparam int DEF    = 256;
    localparam int NUMER  = 2 * WIN * (1 << ACC_W) / 1;
    localparam int MAXINC = (1 << ACC_W) - 1;

    logic             clk = 1'b0;
    logic             rst;
    logic             ref_in;
    logic             sample_en;
    logic [ACC_W-1:0] inc_out;
    logic             cal_done;

    int checks = 0;
    int errors = 0;
    logic ref_en = 1'b0;
    int   ref_half = 32;
    int   wrap_viol = 0;
    logic [ACC_W-1:0] prev_inc;

    always #2 clk = ~clk;

    clkcal_top #(
        .ACC_W       (ACC_W),
        .CNT_W       (20),
        .DIV_W       (20),
        .WIN_EDGES   (WIN),
        .TARGET_HZ   (2),
        .REF_HZ      (1),
        .DEFAULT_INC (DEF)
    ) u_clkcal_top (
        .clk_fast  (clk),
        .rst       (rst),
        .ref_in    (ref_in),
        .sample_en (sample_en),
        .inc_out   (inc_out),
        .cal_done  (cal_done)
    );

    initial begin
        int cnt;
        ref_in = 1'b0;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (ref_en) begin
                cnt++;
                if (cnt >= ref_half) begin
                    ref_in = ~ref_in;
                    cnt = 0;
                end
            end else begin
                ref_in = 1'b0;
                cnt = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            prev_inc = inc_out;
        end else begin
            if (inc_out != prev_inc && !sample_en) wrap_viol++;
            prev_inc = inc_out;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_inc(input int period);
        int q;
        q = NUMER / (WIN * period);
        if (q == 0) q = 1;
        if (q > MAXINC) q = MAXINC;
        return q;
    endfunction

    task automatic count_pulses(input int ncyc, output int n);
        n = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (sample_en) n++;
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 sample_en in reset", int'(sample_en), 0);
        check("R1 inc_out in reset", int'(inc_out), DEF);
        check("R1 cal_done in reset", int'(cal_done), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sample_en after reset", int'(sample_en), 0);
    endtask

    task automatic test_default_no_ref();
        int n;
        int gap;
        repeat (3000) @(negedge clk);
        check("R8 cal_done without reference", int'(cal_done), 0);
        check("R8 inc_out without reference", int'(inc_out), DEF);
        count_pulses(1 << ACC_W, n);
        check("R7 pulses per 2^N at default", n, DEF);
        while (!sample_en) @(negedge clk);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!sample_en);
        check("R7 spacing at default", gap, (1 << ACC_W) / DEF);
    endtask

    task automatic test_period(input int period, input string tag);
        int n;
        int e;
        e = exp_inc(period);
        ref_half = period / 2;
        ref_en = 1'b1;
        repeat (3 * WIN * period + 4300) @(negedge clk);
        check({tag, " cal_done high"}, int'(cal_done), 1);
        check({tag, " increment"}, int'(inc_out), e);
        count_pulses(1 << ACC_W, n);
        check({tag, " pulses per 2^N"}, n, e);
        check("R6 increment changed only at wrap", wrap_viol, 0);
    endtask

    initial begin
        int t = 0;
        forever begin
            @(negedge clk);
            t++;
            if (t > 190000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", t, 190000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1;
        test_reset();
        test_default_no_ref();
        test_period(64, "R3 R4 R9 P=64");
        test_period(100, "R10 R2 P=100");
        test_period(10000, "R5 clamp P=10000");
        check("R9 cal_done stays high", int'(cal_done), 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule